// File: doc/BRIEF.md
# Synthesizer Divider and Sampling-Clock Controller

This block holds the counter logic of a fixed-frequency frequency synthesizer. It runs on one system clock. Three one-cycle enable inputs stand for edges of the reference oscillator, the divided VCO and the second local oscillator. A reference divider and a main divider turn their enables into one-cycle pulses at the comparison rate. A simple detector compares the timing of those two pulse trains and raises a lock flag once they agree for long enough.

A 4-bit comparison-rate code is written with its own strobe. It picks the ratio of a tuning-clock divider, which divides the reference comparison pulses. When the code's top bit is clear, the same write also loads a preset main-divider ratio. Software can still write any main ratio directly. A 2-bit select picks the converter sampling clock: the raw reference level (a test mode), the second-LO enable divided by 12, the same divided by 24, or off.

Top module: `synth_div_ctrl`

## Requirements
- R1: `refPulse` is high for one cycle once every `refRatio` asserted `refTick` cycles. A ratio of 0 means 4096. After reset the first `refTick` produces a pulse.
- R2: After reset the main ratio is 5637. A `mainRatioWr` strobe loads `mainRatioIn` (0 means 32768). `mainPulse` is then high for one cycle once every main-ratio `vcoTick` cycles. `mainRatioWr` takes priority over a `compSelWr` in the same cycle.
- R3: A ratio change never cuts a period in progress. The period running when the write happens completes at its old length, and the new length applies from the next terminal count.
- R4: A `compSelWr` with code 0000, 0001, 0010, 0011 or 0101 loads the main ratio 11274, 7516, 5637, 3758 or 1879 respectively.
- R5: `tunePulse` is high for one cycle once every N `refPulse` events. N is 4 after reset. Codes 0000/1000 set N to 2, 0001/1001 to 3, 0010/1010 to 4, 0011/1011 to 6, 0101/1101 to 12, and 1111 to 24. Codes with the top bit set leave the main ratio unchanged.
- R6: Codes 0100, 0110, 0111, 1100 and 1110 change neither the tuning ratio nor the main ratio.
- R7: `lockDet` rises after 16 consecutive comparison periods in which each `refPulse` and `mainPulse` arrive at most 2 clock cycles apart (including the same cycle).
- R8: A gap of more than 2 cycles between matching pulses clears `lockDet` and restarts the count of good periods.
- R9: With `adcClkSel` 01 the `adcClk` output is high for 6 and low for 6 `lo2Tick` cycles; with 10 it is high for 12 and low for 12. With 00 it equals `refLevel` delayed by one clock.
- R10: With `adcClkSel` 11 the `adcClk` output is held low. A new select is applied only while `adcClk` is low, so a high phase in progress always completes at full width. The first high phase after a switch into a divide mode is full width.
- R11: During and right after reset, all pulse outputs, `lockDet` and `adcClk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference-oscillator edge enable |
| vcoTick | input | 1 | Divided-VCO edge enable |
| lo2Tick | input | 1 | Second-LO edge enable for the sampling clock |
| refLevel | input | 1 | Reference clock level, passed through in test mode |
| refRatio | input | 12 | Reference division ratio (0 = 4096) |
| mainRatioIn | input | 15 | Main division ratio to write (0 = 32768) |
| mainRatioWr | input | 1 | Write strobe for `mainRatioIn` |
| compSel | input | 4 | Comparison-rate code |
| compSelWr | input | 1 | Write strobe for `compSel` |
| adcClkSel | input | 2 | Sampling-clock source: 00 reference, 01 /12, 10 /24, 11 off |
| refPulse | output | 1 | Reference-divider terminal pulse |
| mainPulse | output | 1 | Main-divider terminal pulse |
| tunePulse | output | 1 | Tuning-clock divider pulse |
| lockDet | output | 1 | Lock indication |
| adcClk | output | 1 | Converter sampling clock |

## Verification
A corrupted ratio register shows up as a wrong spacing of `mainPulse` or `tunePulse`. It appears within one period after the next terminal count, so the bench measures the second or third full period after each write. A fault in the pending-pulse tracker of the lock detector changes the cycle in which `lockDet` rises, or whether it falls after a 3-cycle skew. The bench checks the 15th and 16th good periods and the 2-cycle skew boundary. A wrong switch condition in the sampling-clock path produces a shortened high phase, which is visible as soon as the select changes in mid-pulse.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  parameter int REF_W      = 12;
  parameter int MAIN_W     = 15;
  parameter int TUNE_W     = 5;
  parameter int SEL_W      = 4;
  parameter int LOCK_WIN   = 2;
  parameter int LOCK_COUNT = 16;
  parameter int ADC_DIV_A  = 12;
  parameter int ADC_DIV_B  = 24;
  parameter int MAIN_DEF   = 5637;
  parameter int TUNE_DEF   = 4;

  typedef enum logic [1:0] {
    ADC_REF   = 2'b00,
    ADC_DIVA  = 2'b01,
    ADC_DIVB  = 2'b10,
    ADC_OFF   = 2'b11
  } adcSel_t;

  // Strobes and ratios driven by control into the datapath
  typedef struct packed {
    logic [MAIN_W-1:0] mainRatio;
    logic [TUNE_W-1:0] tuneRatio;
  } divCfg_t;

  typedef struct packed {
    logic              tuneValid;
    logic              mainValid;
    logic [MAIN_W-1:0] mainVal;
    logic [TUNE_W-1:0] tuneVal;
  } preset_t;

  function automatic preset_t presetLookup(input logic [SEL_W-1:0] code);
    preset_t p;
    p = '0;
    p.tuneValid = 1'b1;
    p.mainValid = ~code[SEL_W-1];
    unique case (code[SEL_W-2:0])
      3'b000: begin p.tuneVal = TUNE_W'(2);  p.mainVal = MAIN_W'(11274); end
      3'b001: begin p.tuneVal = TUNE_W'(3);  p.mainVal = MAIN_W'(7516);  end
      3'b010: begin p.tuneVal = TUNE_W'(4);  p.mainVal = MAIN_W'(5637);  end
      3'b011: begin p.tuneVal = TUNE_W'(6);  p.mainVal = MAIN_W'(3758);  end
      3'b101: begin p.tuneVal = TUNE_W'(12); p.mainVal = MAIN_W'(1879);  end
      3'b111: begin
        p.tuneVal   = TUNE_W'(24);
        p.tuneValid = code[SEL_W-1];
        p.mainValid = 1'b0;
      end
      default: begin p.tuneValid = 1'b0; p.mainValid = 1'b0; end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/sdc_divider.sv
module sdc_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         pulse
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt == '0) begin
          cnt   <= ratio - W'(1);
          pulse <= 1'b1;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdc_adc_clk.sv
module sdc_adc_clk
  import sdc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lo2Tick,
  input  logic       refLevel,
  input  logic [1:0] selIn,
  output logic       adcClk
);
  localparam int PH_W = $clog2(ADC_DIV_B);

  adcSel_t       activeQ;
  adcSel_t       selReq;
  logic [PH_W-1:0] phaseQ;
  logic [PH_W-1:0] phaseNxt;
  logic [PH_W:0]   lenCur;
  logic [PH_W:0]   lenReq;
  logic            outQ;

  function automatic logic [PH_W:0] lenOf(input adcSel_t s);
    return (s == ADC_DIVB) ? (PH_W+1)'(ADC_DIV_B) : (PH_W+1)'(ADC_DIV_A);
  endfunction

  assign selReq   = adcSel_t'(selIn);
  assign lenCur   = lenOf(activeQ);
  assign lenReq   = lenOf(selReq);
  assign phaseNxt = ({1'b0, phaseQ} == lenCur - 1'b1) ? '0 : phaseQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= ADC_OFF;
      phaseQ  <= '0;
      outQ    <= 1'b0;
    end else if (!outQ && (selReq != activeQ)) begin
      activeQ <= selReq;
      phaseQ  <= PH_W'(lenReq - 1'b1);
      outQ    <= 1'b0;
    end else begin
      unique case (activeQ)
        ADC_REF: outQ <= refLevel;
        ADC_OFF: outQ <= 1'b0;
        default: begin
          if (lo2Tick) begin
            phaseQ <= phaseNxt;
            outQ   <= ({1'b0, phaseNxt} < (lenCur >> 1));
          end
        end
      endcase
    end
  end

  assign adcClk = outQ;
endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             vcoTick,
  input  logic             lo2Tick,
  input  logic             refLevel,
  input  logic [REF_W-1:0] refRatio,
  input  divCfg_t          cfg,
  input  logic [1:0]       adcSel,
  output logic             refPulse,
  output logic             mainPulse,
  output logic             tunePulse,
  output logic             adcClk
);
  sdc_divider #(.W(REF_W)) refDiv_i (
    .clk(clk), .rstN(rstN), .tick(refTick), .ratio(refRatio), .pulse(refPulse)
  );

  sdc_divider #(.W(MAIN_W)) mainDiv_i (
    .clk(clk), .rstN(rstN), .tick(vcoTick), .ratio(cfg.mainRatio), .pulse(mainPulse)
  );

  sdc_divider #(.W(TUNE_W)) tuneDiv_i (
    .clk(clk), .rstN(rstN), .tick(refPulse), .ratio(cfg.tuneRatio), .pulse(tunePulse)
  );

  sdc_adc_clk adcClk_i (
    .clk(clk), .rstN(rstN), .lo2Tick(lo2Tick), .refLevel(refLevel),
    .selIn(adcSel), .adcClk(adcClk)
  );
endmodule

// File: rtl/sdc_control.sv
module sdc_control
  import sdc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MAIN_W-1:0] mainRatioIn,
  input  logic              mainRatioWr,
  input  logic [SEL_W-1:0]  compSel,
  input  logic              compSelWr,
  input  logic              refPulse,
  input  logic              mainPulse,
  output divCfg_t           cfg,
  output logic              lockDet
);
  localparam int AGE_W = $clog2(LOCK_WIN + 1);
  localparam int CNT_W = $clog2(LOCK_COUNT + 1);

  typedef enum logic [1:0] {PEND_NONE, PEND_REF, PEND_MAIN} pend_t;

  logic [MAIN_W-1:0] mainQ;
  logic [TUNE_W-1:0] tuneQ;
  preset_t           preset;

  pend_t             pendQ, pendD;
  logic [AGE_W-1:0]  ageQ, ageD;
  logic [CNT_W-1:0]  goodCnt;
  logic              good, bad;
  logic              lockQ;

  assign preset = presetLookup(compSel);

  // Ratio registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainQ <= MAIN_W'(MAIN_DEF);
      tuneQ <= TUNE_W'(TUNE_DEF);
    end else begin
      if (mainRatioWr) begin
        mainQ <= mainRatioIn;
      end else if (compSelWr && preset.mainValid) begin
        mainQ <= preset.mainVal;
      end
      if (compSelWr && preset.tuneValid) begin
        tuneQ <= preset.tuneVal;
      end
    end
  end

  assign cfg.mainRatio = mainQ;
  assign cfg.tuneRatio = tuneQ;

  // Pending-pulse tracker: one side waits up to LOCK_WIN cycles for the other
  always_comb begin
    good  = 1'b0;
    bad   = 1'b0;
    pendD = pendQ;
    ageD  = ageQ;
    unique case (pendQ)
      PEND_NONE: begin
        if (refPulse && mainPulse) begin
          good = 1'b1;
        end else if (refPulse) begin
          pendD = PEND_REF;
          ageD  = AGE_W'(1);
        end else if (mainPulse) begin
          pendD = PEND_MAIN;
          ageD  = AGE_W'(1);
        end
      end
      PEND_REF: begin
        if (mainPulse) begin
          good  = 1'b1;
          pendD = refPulse ? PEND_REF : PEND_NONE;
          ageD  = AGE_W'(1);
        end else if (refPulse) begin
          bad   = 1'b1;
          ageD  = AGE_W'(1);
        end else if (ageQ == AGE_W'(LOCK_WIN)) begin
          bad   = 1'b1;
          pendD = PEND_NONE;
        end else begin
          ageD  = ageQ + 1'b1;
        end
      end
      default: begin
        if (refPulse) begin
          good  = 1'b1;
          pendD = mainPulse ? PEND_MAIN : PEND_NONE;
          ageD  = AGE_W'(1);
        end else if (mainPulse) begin
          bad   = 1'b1;
          ageD  = AGE_W'(1);
        end else if (ageQ == AGE_W'(LOCK_WIN)) begin
          bad   = 1'b1;
          pendD = PEND_NONE;
        end else begin
          ageD  = ageQ + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= PEND_NONE;
      ageQ    <= '0;
      goodCnt <= '0;
      lockQ   <= 1'b0;
    end else begin
      pendQ <= pendD;
      ageQ  <= ageD;
      if (bad) begin
        goodCnt <= '0;
        lockQ   <= 1'b0;
      end else if (good) begin
        if (goodCnt < CNT_W'(LOCK_COUNT - 1)) begin
          goodCnt <= goodCnt + 1'b1;
        end else begin
          lockQ <= 1'b1;
        end
      end
    end
  end

  assign lockDet = lockQ;
endmodule

// File: rtl/synth_div_ctrl.sv
module synth_div_ctrl
  import sdc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              vcoTick,
  input  logic              lo2Tick,
  input  logic              refLevel,
  input  logic [REF_W-1:0]  refRatio,
  input  logic [MAIN_W-1:0] mainRatioIn,
  input  logic              mainRatioWr,
  input  logic [SEL_W-1:0]  compSel,
  input  logic              compSelWr,
  input  logic [1:0]        adcClkSel,
  output logic              refPulse,
  output logic              mainPulse,
  output logic              tunePulse,
  output logic              lockDet,
  output logic              adcClk
);
  divCfg_t cfg;

  sdc_control ctrl_i (
    .clk(clk), .rstN(rstN),
    .mainRatioIn(mainRatioIn), .mainRatioWr(mainRatioWr),
    .compSel(compSel), .compSelWr(compSelWr),
    .refPulse(refPulse), .mainPulse(mainPulse),
    .cfg(cfg), .lockDet(lockDet)
  );

  sdc_datapath dp_i (
    .clk(clk), .rstN(rstN),
    .refTick(refTick), .vcoTick(vcoTick), .lo2Tick(lo2Tick), .refLevel(refLevel),
    .refRatio(refRatio), .cfg(cfg), .adcSel(adcClkSel),
    .refPulse(refPulse), .mainPulse(mainPulse), .tunePulse(tunePulse),
    .adcClk(adcClk)
  );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import sdc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              refTick,
  input logic              vcoTick,
  input logic              lo2Tick,
  input logic              refLevel,
  input logic [REF_W-1:0]  refRatio,
  input logic [MAIN_W-1:0] mainRatioIn,
  input logic              mainRatioWr,
  input logic [SEL_W-1:0]  compSel,
  input logic              compSelWr,
  input logic [1:0]        adcClkSel,
  input logic              refPulse,
  input logic              mainPulse,
  input logic              tunePulse,
  input logic              lockDet,
  input logic              adcClk
);
  AST_REF_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |-> $past(refTick)); // R1

  AST_MAIN_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    mainPulse |-> $past(vcoTick)); // R2

  AST_TUNE_PULSE_AFTER_REF: assert property (@(posedge clk) disable iff (!rstN)
    tunePulse |-> $past(refPulse)); // R5

  AST_LOCK_RISE_ON_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockDet) |-> $past(refPulse || mainPulse)); // R7

  AST_LOCK_FALL_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockDet) |-> !$past(refPulse && mainPulse)); // R8

  AST_ADC_RISE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcClk) |-> ($past(lo2Tick) || $past(refLevel))); // R9

  AST_ADC_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(adcClkSel) == 2'b11 && adcClkSel == 2'b11 && !$past(adcClk)) |-> !adcClk); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rstN) |-> !(refPulse || mainPulse || tunePulse || lockDet || adcClk)); // R11
endmodule

bind synth_div_ctrl sdc_checker chk_i (.*);

// File: tb/synth_div_ctrl_tb_top.sv
module synth_div_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refRun = 1'b0, vcoRun = 1'b0, lo2Run = 1'b0;
  logic        refLevel = 1'b0;
  logic [11:0] refRatio = 12'd2;
  logic [14:0] mainRatioIn = '0;
  logic        mainRatioWr = 1'b0;
  logic [3:0]  compSel = '0;
  logic        compSelWr = 1'b0;
  logic [1:0]  adcClkSel = 2'b11;
  logic        refPulse, mainPulse, tunePulse, lockDet, adcClk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  synth_div_ctrl dut_i (
    .clk(clk), .rstN(rstN),
    .refTick(refRun), .vcoTick(vcoRun), .lo2Tick(lo2Run), .refLevel(refLevel),
    .refRatio(refRatio), .mainRatioIn(mainRatioIn), .mainRatioWr(mainRatioWr),
    .compSel(compSel), .compSelWr(compSelWr), .adcClkSel(adcClkSel),
    .refPulse(refPulse), .mainPulse(mainPulse), .tunePulse(tunePulse),
    .lockDet(lockDet), .adcClk(adcClk)
  );

  // code, expected tune ratio (0 = unchanged), expected main ratio (0 = unchanged)
  localparam logic [23:0] VEC [13] = '{
    {4'b0000, 5'd2,  15'd11274},
    {4'b0001, 5'd3,  15'd7516},
    {4'b0100, 5'd0,  15'd0},
    {4'b0010, 5'd4,  15'd5637},
    {4'b0011, 5'd6,  15'd3758},
    {4'b0101, 5'd12, 15'd1879},
    {4'b1000, 5'd2,  15'd0},
    {4'b1001, 5'd3,  15'd0},
    {4'b1010, 5'd4,  15'd0},
    {4'b1011, 5'd6,  15'd0},
    {4'b1100, 5'd0,  15'd0},
    {4'b1101, 5'd12, 15'd0},
    {4'b1111, 5'd24, 15'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 ref, 1 main, 2 tune; gap counted in cycles from the call to the pulse
  task automatic waitPulse(input int which, output int gap);
    logic p;
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      p = (which == 0) ? refPulse : (which == 1) ? mainPulse : tunePulse;
    end while (!p && gap < 40000);
  endtask

  task automatic period3(input int which, output int len);
    int g;
    waitPulse(which, g);
    waitPulse(which, g);
    waitPulse(which, len);
  endtask

  task automatic writeMain(input int v);
    @(negedge clk);
    mainRatioIn = 15'(v);
    mainRatioWr = 1'b1;
    @(negedge clk);
    mainRatioWr = 1'b0;
  endtask

  task automatic writeSel(input logic [3:0] c);
    @(negedge clk);
    compSel = c;
    compSelWr = 1'b1;
    @(negedge clk);
    compSelWr = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; refRun = 1'b0; vcoRun = 1'b0; lo2Run = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic measureRun(input logic lvl, output int n);
    int lim;
    lim = 0;
    while (adcClk == lvl && lim < 200) begin @(negedge clk); lim++; end
    while (adcClk != lvl && lim < 400) begin @(negedge clk); lim++; end
    n = 0;
    while (adcClk == lvl && n < 200) begin n++; @(negedge clk); end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int g, len, expT, expM, prevTune, n;
    logic [3:0] code;

    // R11 reset state
    repeat (3) @(negedge clk);
    check(!(refPulse | mainPulse | tunePulse | lockDet | adcClk), "R11", 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!(refPulse | mainPulse | tunePulse | lockDet | adcClk), "R11", 0, 0);

    // R2 default main ratio: first tick pulses, then 5637 period
    vcoRun = 1'b1;
    waitPulse(1, g);
    check(g == 1, "R2", g, 1);
    waitPulse(1, g);
    check(g == 5637, "R2", g, 5637);

    // R1 reference divider, ratio 5 and ratio 0 (4096)
    refRatio = 12'd5; refRun = 1'b1;
    period3(0, len);
    check(len == 5, "R1", len, 5);
    refRatio = 12'd0;
    period3(0, len);
    check(len == 4096, "R1", len, 4096);

    // R5 default tune ratio 4 with reference ratio 2
    refRatio = 12'd2;
    period3(2, len);
    check(len == 8, "R5", len, 8);

    // R2 direct write
    writeMain(37);
    period3(1, len);
    check(len == 37, "R2", len, 37);

    // R3 write mid-period keeps the running period
    writeMain(20);
    period3(1, len);
    waitPulse(1, g);
    repeat (4) @(negedge clk);
    mainRatioIn = 15'd30; mainRatioWr = 1'b1;
    @(negedge clk);
    mainRatioWr = 1'b0;
    waitPulse(1, g);
    check(g + 5 == 20, "R3", g + 5, 20);
    waitPulse(1, g);
    check(g == 30, "R3", g, 30);

    // Table walk: R4 presets, R5 tuning ratios, R6 unused codes
    prevTune = 4;
    for (int i = 0; i < 13; i++) begin
      code = VEC[i][23:20];
      expT = int'(VEC[i][19:15]);
      expM = int'(VEC[i][14:0]);
      writeMain(50);
      writeSel(code);
      period3(1, len);
      if (expM == 0) check(len == 50, (expT == 0) ? "R6" : "R5", len, 50);
      else           check(len == expM, "R4", len, expM);
      if (expT == 0) expT = prevTune;
      period3(2, len);
      check(len == 2 * expT, (VEC[i][19:15] == 5'd0) ? "R6" : "R5", len, 2 * expT);
      prevTune = expT;
    end

    // R7 lock after 16 aligned periods
    doReset();
    refRatio = 12'd10;
    writeMain(10);
    @(negedge clk);
    refRun = 1'b1; vcoRun = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      waitPulse(0, g);
      @(negedge clk);
      if (k == 15) check(lockDet == 1'b0, "R7", lockDet, 0);
      if (k == 16) check(lockDet == 1'b1, "R7", lockDet, 1);
    end

    // R8 skew of 1 then 2 cycles keeps lock
    vcoRun = 1'b0; @(negedge clk); vcoRun = 1'b1;
    repeat (25) @(negedge clk);
    check(lockDet == 1'b1, "R8", lockDet, 1);
    vcoRun = 1'b0; @(negedge clk); vcoRun = 1'b1;
    repeat (25) @(negedge clk);
    check(lockDet == 1'b1, "R8", lockDet, 1);
    // skew of 4 cycles clears lock
    vcoRun = 1'b0; repeat (2) @(negedge clk); vcoRun = 1'b1;
    repeat (25) @(negedge clk);
    check(lockDet == 1'b0, "R8", lockDet, 0);

    // R9 sampling clock divide modes
    lo2Run = 1'b1;
    adcClkSel = 2'b01;
    measureRun(1'b1, n);
    check(n == 6, "R9", n, 6);
    measureRun(1'b0, n);
    check(n == 6, "R9", n, 6);
    adcClkSel = 2'b10;
    measureRun(1'b1, n);
    check(n == 12, "R9", n, 12);
    measureRun(1'b0, n);
    check(n == 12, "R9", n, 12);

    // R10 switch off in mid-high: full high phase, then held low
    while (adcClk) @(negedge clk);
    while (!adcClk) @(negedge clk);
    n = 0;
    adcClkSel = 2'b11;
    while (adcClk && n < 100) begin n++; @(negedge clk); end
    check(n == 12, "R10", n, 12);
    g = 0;
    for (int k = 0; k < 40; k++) begin
      if (adcClk) g++;
      @(negedge clk);
    end
    check(g == 0, "R10", g, 0);
    adcClkSel = 2'b01;
    measureRun(1'b1, n);
    check(n == 6, "R10", n, 6);

    // R9 reference pass-through mode
    adcClkSel = 2'b00;
    refLevel = 1'b0;
    repeat (20) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      refLevel = (k % 3 != 1);
      @(negedge clk);
      check(adcClk == refLevel, "R9", adcClk, refLevel);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule